// File: doc/BRIEF.md
# Interrupt Status Register Aggregator

This block gathers interrupt causes from a telecom serial-interface controller into one 8-bit status register that a microprocessor reads after an interrupt. Several causes arrive as one-cycle pulses. These are timer expiry, command-FIFO completion, monitor channel found, synchronous access window open, and overflow. Each pulse sets a sticky bit, and a read of the register clears that bit. The signaling FIFO bit behaves differently. It mirrors the FIFO's non-empty level and ignores reads. The framing bit reports every change of an asynchronous PCM synchronization level. That level first passes through a two-flop synchronizer and then an edge detector.

The register responds at one of two addresses, depending on the bus mode. Each read captures a registered snapshot onto the read-data port. A single request line stays high while any status bit is set.

Top module: `irq_status_agg`

## Requirements
- R1: Bit layout, from bit 7 down to bit 0: timer (7), signaling FIFO (6), command done (5), monitor active (4), PCM framing (3), constant 0 (2), synchronous transfer (1), overflow (0). Bit 2 always reads 0.
- R2: While reset is held and after it is released, with no events, `rdData` is 0x00 and `irqReq` is 0.
- R3: A read is accepted only in two cases. The first is `busMuxed`=0 with `bankSel`=0 and `rdAddr`=0x0E. The second is `busMuxed`=1 with `rdAddr`=0x1C. Any other access leaves `rdData` unchanged and clears nothing.
- R4: An accepted read clears bits 7, 5, 4, 3, 1 and 0.
- R5: Bit 6 equals `sigFifoNotEmpty` as sampled one clock earlier, and a read does not clear it.
- R6: Every `timerEvt` pulse sets bit 7 again, including after it has been read and cleared.
- R7: Bit 3 is set by both rising and falling changes of `pcmSyncLvl`. The change becomes visible three clock edges after the input changes: two synchronizer stages, then the edge register.
- R8: A `syncWinEvt` pulse sets bit 1 only when `chanAEn` or `chanBEn` is 1. Otherwise the pulse is ignored.
- R9: If a set event and an accepted read occur in the same cycle, the bit ends up set. The read returns the value from before the event.
- R10: `irqReq` is 1 exactly when any status bit is set.
- R11: An accepted read loads `rdData` with the status value held in that cycle. The value is visible after that clock edge and is held until the next accepted read.
- R12: The pulses `cmdDoneEvt`, `monFoundEvt` and `ovflEvt` set bits 5, 4 and 0 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| timerEvt | input | 1 | Timer expiry pulse |
| cmdDoneEvt | input | 1 | Command FIFO done pulse |
| monFoundEvt | input | 1 | Active monitor channel found pulse |
| syncWinEvt | input | 1 | Processor access window open pulse |
| ovflEvt | input | 1 | Overflow pulse |
| sigFifoNotEmpty | input | 1 | Signaling FIFO holds a valid entry |
| pcmSyncLvl | input | 1 | Asynchronous PCM synchronization level |
| chanAEn | input | 1 | Synchronous channel A enable |
| chanBEn | input | 1 | Synchronous channel B enable |
| busMuxed | input | 1 | 1 selects multiplexed bus addressing |
| bankSel | input | 1 | Register bank select, must be 0 in demultiplexed mode |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | 5 | Read address |
| rdData | output | 8 | Snapshot of the status register |
| irqReq | output | 1 | Interrupt request |

## Verification
Several internal faults would show up on the ports. A wrong bit position or a sticky bit that never clears shows in `rdData` on the first accepted read after the event. It also shows on `irqReq`, which stays high through a read that should have dropped it. A broken address decode shows as a read that changes `rdData` when it should not, or as an accepted read that fails to lower `irqReq` on the next edge. A lost collision event or a synchronizer of the wrong length shows within one read, or within three edges of the PCM level change.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

  localparam int STAT_W  = 8;
  localparam int BIT_TMR = 7;
  localparam int BIT_SFI = 6;
  localparam int BIT_CMD = 5;
  localparam int BIT_MON = 4;
  localparam int BIT_PCM = 3;
  localparam int BIT_NIL = 2;
  localparam int BIT_SYN = 1;
  localparam int BIT_OVF = 0;

  typedef enum logic [1:0] {
    KIND_ZERO,
    KIND_LEVEL,
    KIND_STICKY
  } bitKind_t;

  typedef struct packed {
    logic rdHit;
    logic pcmEdge;
    logic syncSet;
  } ctrlStrobes_t;

  function automatic bitKind_t bitKindOf(input int idx);
    if (idx == BIT_NIL)      return KIND_ZERO;
    else if (idx == BIT_SFI) return KIND_LEVEL;
    else                     return KIND_STICKY;
  endfunction

endpackage

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DEMUX_ADDR  = 'h0E,
  parameter int MUX_ADDR    = 'h1C,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busMuxed,
  input  logic              bankSel,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              pcmSyncLvl,
  input  logic              syncWinEvt,
  input  logic              chanAEn,
  input  logic              chanBEn,
  output ctrlStrobes_t      strb
);

  localparam logic [ADDR_W-1:0] DEMUX_A = ADDR_W'(DEMUX_ADDR);
  localparam logic [ADDR_W-1:0] MUX_A   = ADDR_W'(MUX_ADDR);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   pcmLast;
  logic                   demuxHit;
  logic                   muxHit;

  // synchronizer for the asynchronous level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '0;
      pcmLast   <= 1'b0;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], pcmSyncLvl};
      pcmLast   <= syncChain[SYNC_STAGES-1];
    end
  end

  always_comb begin
    demuxHit = !busMuxed && !bankSel && (rdAddr == DEMUX_A);
    muxHit   = busMuxed && (rdAddr == MUX_A);
  end

  always_comb begin
    strb.rdHit   = rdEn && (demuxHit || muxHit);
    strb.pcmEdge = syncChain[SYNC_STAGES-1] ^ pcmLast;
    strb.syncSet = syncWinEvt && (chanAEn || chanBEn);
  end

endmodule

// File: rtl/irq_status_dp.sv
module irq_status_dp
  import irq_status_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic              timerEvt,
  input  logic              cmdDoneEvt,
  input  logic              monFoundEvt,
  input  logic              ovflEvt,
  input  logic              sigFifoNotEmpty,
  output logic [STAT_W-1:0] statusQ,
  output logic [STAT_W-1:0] rdData,
  output logic              irqReq
);

  logic [STAT_W-1:0] setVec;

  always_comb begin
    setVec          = '0;
    setVec[BIT_TMR] = timerEvt;
    setVec[BIT_CMD] = cmdDoneEvt;
    setVec[BIT_MON] = monFoundEvt;
    setVec[BIT_PCM] = strb.pcmEdge;
    setVec[BIT_SYN] = strb.syncSet;
    setVec[BIT_OVF] = ovflEvt;
  end

  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    logic bitQ;
    if (bitKindOf(b) == KIND_ZERO) begin : g_zero
      assign bitQ = 1'b0;
    end else if (bitKindOf(b) == KIND_LEVEL) begin : g_level
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) bitQ <= 1'b0;
        else       bitQ <= sigFifoNotEmpty;
      end
    end else begin : g_sticky
      // a set in the same cycle as a clearing read wins
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)            bitQ <= 1'b0;
        else if (setVec[b])   bitQ <= 1'b1;
        else if (strb.rdHit)  bitQ <= 1'b0;
      end
    end
    assign statusQ[b] = bitQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rdData <= '0;
    else if (strb.rdHit) rdData <= statusQ;
  end

  assign irqReq = |statusQ;

endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irq_status_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DEMUX_ADDR = 'h0E,
  parameter int MUX_ADDR   = 'h1C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              timerEvt,
  input  logic              cmdDoneEvt,
  input  logic              monFoundEvt,
  input  logic              syncWinEvt,
  input  logic              ovflEvt,
  input  logic              sigFifoNotEmpty,
  input  logic              pcmSyncLvl,
  input  logic              chanAEn,
  input  logic              chanBEn,
  input  logic              busMuxed,
  input  logic              bankSel,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              irqReq
);

  ctrlStrobes_t      strobes;
  logic [STAT_W-1:0] statusQ;

  irq_status_ctrl #(
    .ADDR_W     (ADDR_W),
    .DEMUX_ADDR (DEMUX_ADDR),
    .MUX_ADDR   (MUX_ADDR),
    .SYNC_STAGES(2)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busMuxed  (busMuxed),
    .bankSel   (bankSel),
    .rdEn      (rdEn),
    .rdAddr    (rdAddr),
    .pcmSyncLvl(pcmSyncLvl),
    .syncWinEvt(syncWinEvt),
    .chanAEn   (chanAEn),
    .chanBEn   (chanBEn),
    .strb      (strobes)
  );

  irq_status_dp u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strb           (strobes),
    .timerEvt       (timerEvt),
    .cmdDoneEvt     (cmdDoneEvt),
    .monFoundEvt    (monFoundEvt),
    .ovflEvt        (ovflEvt),
    .sigFifoNotEmpty(sigFifoNotEmpty),
    .statusQ        (statusQ),
    .rdData         (rdData),
    .irqReq         (irqReq)
  );

endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk (
  input logic       clk,
  input logic       rstN,
  input logic       rdHit,
  input logic       pcmEdge,
  input logic       timerEvt,
  input logic       cmdDoneEvt,
  input logic       monFoundEvt,
  input logic       syncWinEvt,
  input logic       ovflEvt,
  input logic       sigFifoNotEmpty,
  input logic       chanAEn,
  input logic       chanBEn,
  input logic [7:0] statusQ,
  input logic [7:0] rdData,
  input logic       irqReq
);

  assert_zero_bit_R1: assert property (@(posedge clk) disable iff (!rstN)
    rdData[2] == 1'b0);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !rdHit |=> $stable(rdData));

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdHit && !timerEvt && !cmdDoneEvt && !monFoundEvt && !ovflEvt
     && !syncWinEvt && !pcmEdge) |=> ((statusQ & 8'hBB) == 8'h00));

  assert_fifo_follow_R5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (statusQ[6] == $past(sigFifoNotEmpty)));

  assert_sync_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusQ[1]) |-> $past(syncWinEvt && (chanAEn || chanBEn)));

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdHit && timerEvt) |=> statusQ[7]);

  assert_timer_irq_R10: assert property (@(posedge clk) disable iff (!rstN)
    timerEvt |=> irqReq);

  assert_snapshot_R11: assert property (@(posedge clk) disable iff (!rstN)
    rdHit |=> (rdData == $past(statusQ)));

endmodule

bind irq_status_agg irq_status_chk u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .rdHit          (strobes.rdHit),
  .pcmEdge        (strobes.pcmEdge),
  .timerEvt       (timerEvt),
  .cmdDoneEvt     (cmdDoneEvt),
  .monFoundEvt    (monFoundEvt),
  .syncWinEvt     (syncWinEvt),
  .ovflEvt        (ovflEvt),
  .sigFifoNotEmpty(sigFifoNotEmpty),
  .chanAEn        (chanAEn),
  .chanBEn        (chanBEn),
  .statusQ        (statusQ),
  .rdData         (rdData),
  .irqReq         (irqReq)
);

// File: tb/irq_status_agg_bench.sv
module irq_status_agg_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam logic [4:0] A_DEMUX = 5'h0E;
  localparam logic [4:0] A_MUX   = 5'h1C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic timerEvt = 0, cmdDoneEvt = 0, monFoundEvt = 0, syncWinEvt = 0, ovflEvt = 0;
  logic sigFifoNotEmpty = 0, pcmSyncLvl = 0, chanAEn = 0, chanBEn = 0;
  logic busMuxed = 0, bankSel = 0, rdEn = 0;
  logic [4:0] rdAddr = '0;
  logic [7:0] rdData;
  logic irqReq;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit modelOn = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_agg u_irq_status_agg (
    .clk(clk), .rstN(rstN), .timerEvt(timerEvt), .cmdDoneEvt(cmdDoneEvt),
    .monFoundEvt(monFoundEvt), .syncWinEvt(syncWinEvt), .ovflEvt(ovflEvt),
    .sigFifoNotEmpty(sigFifoNotEmpty), .pcmSyncLvl(pcmSyncLvl),
    .chanAEn(chanAEn), .chanBEn(chanBEn), .busMuxed(busMuxed),
    .bankSel(bankSel), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .irqReq(irqReq)
  );

  // reference model built from the requirements
  logic [7:0] mSt = '0, mRd = '0;
  logic p1 = 0, p2 = 0, p3 = 0;

  function automatic logic isHit(logic m, logic b, logic e, logic [4:0] a);
    return e && (m ? (a == A_MUX) : (!b && a == A_DEMUX));
  endfunction

  function automatic logic [7:0] nextStatus(logic [7:0] s, logic hit, logic edgeSeen);
    logic [7:0] n;
    n = hit ? (s & 8'h44) : s;
    if (timerEvt)    n[7] = 1'b1;
    if (cmdDoneEvt)  n[5] = 1'b1;
    if (monFoundEvt) n[4] = 1'b1;
    if (edgeSeen)    n[3] = 1'b1;
    if (syncWinEvt && (chanAEn || chanBEn)) n[1] = 1'b1;
    if (ovflEvt)     n[0] = 1'b1;
    n[6] = sigFifoNotEmpty;
    n[2] = 1'b0;
    return n;
  endfunction

  always @(posedge clk) begin
    logic h;
    if (!rstN) begin
      mSt = '0; mRd = '0; p1 = 0; p2 = 0; p3 = 0;
    end else begin
      h = isHit(busMuxed, bankSel, rdEn, rdAddr);
      if (h) mRd = mSt;
      mSt = nextStatus(mSt, h, p2 ^ p3);
      p3 = p2; p2 = p1; p1 = pcmSyncLvl;
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (modelOn) begin
      check("R10 irq vs model", {7'd0, irqReq}, {7'd0, |mSt});
      check("R11 rdData vs model", rdData, mRd);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doRead(logic m, logic b, logic [4:0] a);
    busMuxed = m; bankSel = b; rdAddr = a; rdEn = 1;
    tick();
    rdEn = 0; bankSel = 0;
  endtask

  task automatic pulse(ref logic sig);
    sig = 1; tick(); sig = 0;
  endtask

  initial begin
    void'($urandom(32'd7531));
    tick(2);
    check("R2 reset rdData", rdData, 8'h00);
    check("R2 reset irq", {7'd0, irqReq}, 8'h00);
    rstN = 1;
    tick(2);
    modelOn = 1;
    check("R2 idle irq", {7'd0, irqReq}, 8'h00);

    // R1, R12: all pulse sources at once
    chanAEn = 1;
    timerEvt = 1; cmdDoneEvt = 1; monFoundEvt = 1; syncWinEvt = 1; ovflEvt = 1;
    tick();
    timerEvt = 0; cmdDoneEvt = 0; monFoundEvt = 0; syncWinEvt = 0; ovflEvt = 0;
    chanAEn = 0;
    check("R12 irq after pulses", {7'd0, irqReq}, 8'h01);
    doRead(0, 0, A_DEMUX);
    check("R1 R12 layout", rdData, 8'hA3 | 8'h10);
    check("R4 cleared by read", {7'd0, irqReq}, 8'h00);

    // R6: repeated timer
    pulse(timerEvt); doRead(0, 0, A_DEMUX);
    check("R6 first expiry", rdData, 8'h80);
    pulse(timerEvt); doRead(0, 0, A_DEMUX);
    check("R6 second expiry", rdData, 8'h80);

    // R5: FIFO level bit ignores reads
    sigFifoNotEmpty = 1; tick();
    doRead(0, 0, A_DEMUX);
    check("R5 fifo set", rdData, 8'h40);
    doRead(0, 0, A_DEMUX);
    check("R5 fifo survives read", rdData, 8'h40);
    check("R5 irq held", {7'd0, irqReq}, 8'h01);
    sigFifoNotEmpty = 0; tick();
    check("R5 irq drops with fifo", {7'd0, irqReq}, 8'h00);

    // R7: both edges of the PCM level, three edges of latency
    pcmSyncLvl = 1; tick(2);
    check("R7 not yet visible", {7'd0, irqReq}, 8'h00);
    tick();
    check("R7 rise visible", {7'd0, irqReq}, 8'h01);
    doRead(0, 0, A_DEMUX);
    check("R7 rise", rdData, 8'h08);
    pcmSyncLvl = 0; tick(4);
    doRead(1, 0, A_MUX);
    check("R7 fall", rdData, 8'h08);

    // R8: gating by channel enables
    pulse(syncWinEvt); doRead(0, 0, A_DEMUX);
    check("R8 gated off", rdData, 8'h00);
    chanBEn = 1; pulse(syncWinEvt); chanBEn = 0; doRead(0, 0, A_DEMUX);
    check("R8 enabled", rdData, 8'h02);

    // R9: set and read in the same cycle
    pulse(monFoundEvt);
    timerEvt = 1; doRead(0, 0, A_DEMUX); timerEvt = 0;
    check("R9 read returns old value", rdData, 8'h10);
    doRead(0, 0, A_DEMUX);
    check("R9 event kept", rdData, 8'h80);

    // R3: address decode
    pulse(ovflEvt);
    doRead(0, 1, A_DEMUX);
    check("R3 bank select blocks", rdData, 8'h80);
    doRead(1, 0, A_DEMUX);
    check("R3 wrong mux address", rdData, 8'h80);
    doRead(0, 0, A_MUX);
    check("R3 wrong demux address", rdData, 8'h80);
    check("R3 nothing cleared", {7'd0, irqReq}, 8'h01);
    doRead(1, 0, A_MUX);
    check("R3 mux address", rdData, 8'h01);

    // random phase, checked against the model every cycle
    for (int i = 0; i < 3000; i++) begin
      int sel;
      timerEvt    = ($urandom_range(0, 11) == 0);
      cmdDoneEvt  = ($urandom_range(0, 11) == 0);
      monFoundEvt = ($urandom_range(0, 11) == 0);
      syncWinEvt  = ($urandom_range(0, 7) == 0);
      ovflEvt     = ($urandom_range(0, 15) == 0);
      chanAEn     = ($urandom_range(0, 3) == 0);
      chanBEn     = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 19) == 0) sigFifoNotEmpty = ~sigFifoNotEmpty;
      if ($urandom_range(0, 9) == 0)  pcmSyncLvl = ~pcmSyncLvl;
      busMuxed = $urandom_range(0, 1);
      bankSel  = ($urandom_range(0, 3) == 0);
      rdEn     = ($urandom_range(0, 2) == 0);
      sel      = $urandom_range(0, 3);
      rdAddr   = (sel == 0) ? A_DEMUX : (sel == 1) ? A_MUX : 5'($urandom_range(0, 31));
      tick();
    end
    timerEvt = 0; cmdDoneEvt = 0; monFoundEvt = 0; syncWinEvt = 0; ovflEvt = 0;
    rdEn = 0;
    tick(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule